// File: doc/BRIEF.md
# Dual-Encoding Serial Clock Prescaler

This block turns the core clock into toggle-enable pulses for a serial-bus clock. The caller supplies an 8-bit prescale byte and a mode bit. The mode bit picks one of two ways to read the byte:

- **Offset encoding.** Only even ratios from 4 to 30 are possible.
- **Mantissa/exponent encoding.** The ratio is a 4-bit multiplier times a power of two. The three exponent bits are split between bit 4 and bits 7:6 of the byte.

Bit 5 of the byte is never part of the prescale value.

While `run` is low, the block copies the mode and byte into an internal setting. While `run` is high, the setting is frozen. The block then counts core cycles and emits a one-cycle `tick` at the end of each half-period. A shifter can toggle its serial clock on every tick. Settings that cannot be honoured raise `cfg_err`, and no ticks are produced while that flag is high. Working out the byte from a target bit rate is left to software.

Top module: `sck_prescaler`

## Requirements
- R1: After reset, `tick` is 0 and `cfg_err` is 1, because the stored setting resets to offset encoding with a byte of zero.
- R2: With `ext_mode`=0, let F be the byte's bits 4:0. For F from 0x12 to 0x1F, the ratio is D=2*(F-16). Each half-period lasts D/2 cycles.
- R3: With `ext_mode`=0, bits 7:5 of the byte have no effect.
- R4: With `ext_mode`=0, a value of F below 0x12 raises `cfg_err`, and no tick is produced.
- R5: With `ext_mode`=1, the multiplier M is bits 3:0. The exponent E is formed as {bit7, bit6, bit4}. The ratio is D=M*2^E, and bit 5 has no effect.
- R6: With `ext_mode`=1, a multiplier of 0 or 1 raises `cfg_err`, and no tick is produced.
- R7: The two half-periods alternate. The first lasts floor(D/2) cycles and the second lasts D-floor(D/2) cycles, so an odd ratio makes the first half the shorter one. Every start of `run` begins with the first half.
- R8: The setting is captured on each clock edge at which `run` is low. Changes to the inputs while `run` is high are ignored until `run` drops.
- R9: While `run` is low, no tick is produced and the counter reloads, so each run starts at cycle zero of the first half.
- R10: Let L be the length of the current half-period. The tick is high in the cycle after the L-th consecutive edge at which `run` is sampled high in that half. The flag `cfg_err` reflects a new setting from the edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_mode | input | 1 | 0 selects offset encoding, 1 selects mantissa/exponent encoding |
| presc | input | 8 | Prescale byte |
| run | input | 1 | High while a word is being shifted |
| tick | output | 1 | One-cycle toggle-enable pulse for the serial clock |
| cfg_err | output | 1 | The stored setting is invalid |

## Verification
A change to `presc` or `ext_mode` made while `run` is low shows on `cfg_err` one edge later. A rise of `run` produces its first `tick` L edges later, where L is the first half-period. The bench runs a behavioural model that takes the same clock edges and rebuilds the ratio arithmetically from R2 and R5. Inputs are driven on the falling edge, and `tick` and `cfg_err` are compared with the model on every falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/sckp_pkg.sv
package sckp_pkg;
   localparam int FIELD_W  = 8;
   localparam int SPR_W    = 4;
   localparam int EXP_W    = 3;
   localparam int LEG_W    = 5;
   localparam int LEG_BASE = 16;
   localparam int LEG_MIN  = 18;
   localparam int SPR_MIN  = 2;
   localparam int N_EXP    = 1 << EXP_W;
   // widest half-period: (2^SPR_W - 1) << (N_EXP - 2)
   localparam int HALF_W   = SPR_W + N_EXP - 2;

   typedef struct packed {
      logic               ext;
      logic [FIELD_W-1:0] field;
   } sckp_cfg_t;
endpackage

// File: rtl/sckp_decode.sv
module sckp_decode
   import sckp_pkg::*;
#(
   parameter int CNT_W = HALF_W
) (
   input  sckp_cfg_t        cfg,
   output logic [CNT_W-1:0] len_a,
   output logic [CNT_W-1:0] len_b,
   output logic             err
);
   generate
      if (CNT_W < HALF_W) begin : g_bad_width
         $error("sckp_decode: CNT_W too narrow for the largest half-period");
      end
   endgenerate

   logic [SPR_W-1:0] spr;
   logic [EXP_W-1:0] expo;
   logic [LEG_W-1:0] leg;
   logic [CNT_W-1:0] cand [N_EXP];

   // exponent bit 0 sits at bit 4, bits 2:1 at bits 7:6; bit 5 unused
   assign spr  = cfg.field[SPR_W-1:0];
   assign expo = {cfg.field[7:6], cfg.field[4]};
   assign leg  = cfg.field[LEG_W-1:0];

   // candidate equal halves for each exponent value (E >= 1)
   genvar e;
   generate
      for (e = 0; e < N_EXP; e++) begin : g_cand
         if (e == 0) begin : g_zero
            assign cand[e] = '0;
         end else begin : g_shift
            assign cand[e] = CNT_W'(spr) << (e - 1);
         end
      end
   endgenerate

   logic [CNT_W-1:0] spr_lo;
   assign spr_lo = CNT_W'(spr >> 1);

   always_comb begin
      if (cfg.ext) begin
         err = (spr < SPR_W'(SPR_MIN));
         if (expo == '0) begin
            len_a = spr_lo;
            len_b = CNT_W'(spr) - spr_lo;
         end else begin
            len_a = cand[expo];
            len_b = cand[expo];
         end
      end else begin
         err   = (leg < LEG_W'(LEG_MIN));
         len_a = CNT_W'(leg) - CNT_W'(LEG_BASE);
         len_b = CNT_W'(leg) - CNT_W'(LEG_BASE);
      end
   end
endmodule

// File: rtl/sckp_phase_ctr.sv
module sckp_phase_ctr #(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             err,
   input  logic [CNT_W-1:0] len_a,
   input  logic [CNT_W-1:0] len_b,
   output logic             tick
);
   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("sckp_phase_ctr: CNT_W must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   logic             second;
   logic [CNT_W-1:0] len_now;
   logic             last;

   assign len_now = second ? len_b : len_a;
   assign last    = (cnt == len_now - CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         second <= 1'b0;
         tick   <= 1'b0;
      end else if (!run || err) begin
         cnt    <= '0;
         second <= 1'b0;
         tick   <= 1'b0;
      end else if (last) begin
         cnt    <= '0;
         second <= ~second;
         tick   <= 1'b1;
      end else begin
         cnt    <= cnt + CNT_W'(1);
         tick   <= 1'b0;
      end
   end
endmodule

// File: rtl/sck_prescaler.sv
module sck_prescaler
   import sckp_pkg::*;
#(
   parameter int CNT_W = HALF_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ext_mode,
   input  logic [FIELD_W-1:0] presc,
   input  logic               run,
   output logic               tick,
   output logic               cfg_err
);
   sckp_cfg_t        cfg_q;
   logic [CNT_W-1:0] len_a;
   logic [CNT_W-1:0] len_b;

   // setting frozen for the whole of a run
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cfg_q <= '0;
      else if (!run) cfg_q <= '{ext: ext_mode, field: presc};
   end

   sckp_decode #(.CNT_W(CNT_W)) u_dec (
      .cfg   (cfg_q),
      .len_a (len_a),
      .len_b (len_b),
      .err   (cfg_err)
   );

   sckp_phase_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .err   (cfg_err),
      .len_a (len_a),
      .len_b (len_b),
      .tick  (tick)
   );
endmodule

// File: rtl/sckp_chk.sv
module sckp_chk (
   input logic clk,
   input logic rst_n,
   input logic run,
   input logic tick,
   input logic cfg_err
);
   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !tick);

   // covers R6 as well: an invalid extended setting is flagged the same way
   assert_err_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |=> !tick);

   assert_cfg_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
      run |=> $stable(cfg_err));

   assert_tick_needs_run_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tick) |-> $past(run));
endmodule

bind sck_prescaler sckp_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .run     (run),
   .tick    (tick),
   .cfg_err (cfg_err)
);

// File: tb/sck_prescaler_test.sv
module sck_prescaler_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ext_mode = 1'b0;
   logic [7:0] presc = 8'h00;
   logic       run = 1'b0;
   logic       tick;
   logic       cfg_err;

   int    n_checks = 0;
   int    n_fail   = 0;
   int    cyc      = 0;
   string cur_req  = "R1";
   bit    done     = 1'b0;

   // behavioural reference state
   int m_ext = 0, m_field = 0, m_cnt = 0, m_phase = 0, m_tick = 0;

   always #5 clk = ~clk;

   sck_prescaler uut (
      .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .presc(presc),
      .run(run), .tick(tick), .cfg_err(cfg_err)
   );

   function automatic int ratio(int ext, int f);
      if (ext != 0)
         return (f % 16) * (1 << (((f / 64) % 4) * 2 + ((f / 16) % 2)));
      return 2 * ((f % 32) - 16);
   endfunction

   function automatic int bad(int ext, int f);
      if (ext != 0) return ((f % 16) < 2) ? 1 : 0;
      return ((f % 32) < 18) ? 1 : 0;
   endfunction

   always @(posedge clk) begin
      int d, len;
      if (!rst_n) begin
         m_ext = 0; m_field = 0; m_cnt = 0; m_phase = 0; m_tick = 0;
      end else begin
         if (!run || bad(m_ext, m_field) != 0) begin
            m_cnt = 0; m_phase = 0; m_tick = 0;
         end else begin
            d   = ratio(m_ext, m_field);
            len = (m_phase == 0) ? d / 2 : d - d / 2;
            m_cnt = m_cnt + 1;
            if (m_cnt == len) begin
               m_cnt = 0; m_phase = 1 - m_phase; m_tick = 1;
            end else m_tick = 0;
         end
         if (!run) begin m_ext = int'(ext_mode); m_field = int'(presc); end
      end
      cyc++;
   end

   task automatic check(string req, string what, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s at cycle %0d: actual=%0d expected=%0d", req, what, cyc, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(cur_req, "tick", int'(tick), m_tick);
         check(cur_req, "cfg_err", int'(cfg_err), bad(m_ext, m_field));
      end
   end

   task automatic word(string req, bit ext, logic [7:0] f, int n);
      @(negedge clk);
      cur_req = req; ext_mode = ext; presc = f; run = 1'b0;
      repeat (2) @(negedge clk);
      run = 1'b1;
      repeat (n) @(negedge clk);
      run = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "reset tick", int'(tick), 0);
      check("R1", "reset err", int'(cfg_err), 1);
      word("R2", 1'b0, 8'h12, 30);
      word("R2", 1'b0, 8'h1F, 70);
      word("R10", 1'b0, 8'h14, 25);
      word("R3", 1'b0, 8'hF4, 25);
      word("R4", 1'b0, 8'h11, 20);
      word("R4", 1'b0, 8'h00, 10);
      word("R5", 1'b1, 8'h93, 200);
      word("R5", 1'b1, 8'h2C, 40);
      word("R5", 1'b1, 8'hD2, 300);
      word("R6", 1'b1, 8'h01, 15);
      word("R6", 1'b1, 8'hD0, 15);
      word("R7", 1'b1, 8'h05, 30);
      word("R7", 1'b1, 8'h02, 10);
      word("R7", 1'b1, 8'h0F, 40);
      // R8: inputs changed mid-run are ignored
      @(negedge clk);
      cur_req = "R8"; ext_mode = 1'b0; presc = 8'h13; run = 1'b0;
      repeat (2) @(negedge clk);
      run = 1'b1;
      repeat (7) @(negedge clk);
      ext_mode = 1'b1; presc = 8'h01;
      repeat (20) @(negedge clk);
      check("R8", "err frozen", int'(cfg_err), 0);
      run = 1'b0;
      @(negedge clk);
      check("R8", "err after capture", int'(cfg_err), 1);
      // R9: drop run mid-half and restart from the first half
      cur_req = "R9"; ext_mode = 1'b1; presc = 8'h07;
      repeat (2) @(negedge clk);
      run = 1'b1;
      repeat (5) @(negedge clk);
      run = 1'b0;
      repeat (3) @(negedge clk);
      run = 1'b1;
      repeat (20) @(negedge clk);
      run = 1'b0;
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
      $finish;
   end

   initial begin
      #200000;
      n_checks++;
      n_fail++;
      done = 1'b1;
      $display("FAIL watchdog expired at cycle %0d: actual=hung expected=finished", cyc);
      $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
      $finish;
   end
endmodule